// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised storage register (eight bits by default) with four synchronous operating modes. Two select inputs pick the mode: hold the current contents, shift toward the high bit, shift toward the low bit, or load all bits in parallel. A separate serial input feeds each end of the register. The two end bits are always brought out as serial taps, so several units can be strung together to move data in either direction or to circulate it around a loop.

Parallel data shares one bidirectional bus for both directions. For synthesis the bus is split into an input vector, an output vector and a single output-enable. The bus is driven only when both active-low enables are asserted and the register is not in load mode. Selecting load mode always releases the bus so that the register can capture it, whatever the enables say. An active-low master reset clears every bit at once, without waiting for a clock edge.

Top module: `usr_shift_reg`

## Requirements
- R1: With {sel1,sel0} = 2'b00 (hold), a rising clock edge leaves the register contents unchanged.
- R2: With {sel1,sel0} = 2'b01 (shift up), each rising edge moves bit i into bit i+1 and puts ser_lo_in into bit 0.
- R3: With {sel1,sel0} = 2'b10 (shift down), each rising edge moves bit i into bit i-1 and puts ser_hi_in into bit WIDTH-1.
- R4: With {sel1,sel0} = 2'b11 (load), one rising edge copies bus_in into the register, whatever the levels of oe1_n and oe2_n.
- R5: While mr_n is low, the register reads all zeros. This takes effect without a clock edge and overrides the select, serial and bus inputs.
- R6: bus_oe is high exactly when oe1_n and oe2_n are both low and the mode is not load. bus_out always carries the present register contents.
- R7: In load mode bus_oe is low, even with both enables low.
- R8: If oe1_n or oe2_n is high, bus_oe is low.
- R9: tap_lo equals register bit 0 and tap_hi equals bit WIDTH-1 at all times, including while bus_oe is low.
- R10: Two units can be chained in either direction. In the upward direction, tap_hi of the lower unit feeds ser_lo_in of the upper unit. In the downward direction, tap_lo of the upper unit feeds ser_hi_in of the lower unit. The pair then behaves as one 2×WIDTH register, and feeding the upper tap_hi back to the lower ser_lo_in recirculates all of its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mr_n | input | 1 | Asynchronous master clear, active low |
| sel0 | input | 1 | Mode select, low bit |
| sel1 | input | 1 | Mode select, high bit |
| oe1_n | input | 1 | Bus output enable one, active low |
| oe2_n | input | 1 | Bus output enable two, active low |
| ser_lo_in | input | 1 | Serial input entering bit 0 in shift-up mode |
| ser_hi_in | input | 1 | Serial input entering the top bit in shift-down mode |
| bus_in | input | WIDTH | Bus value seen by the register (load source) |
| bus_out | output | WIDTH | Value driven onto the bus when enabled |
| bus_oe | output | 1 | High when the block drives the bus |
| tap_lo | output | 1 | Serial output, register bit 0 |
| tap_hi | output | 1 | Serial output, register top bit |

## Verification
Every register result is due one rising edge after the inputs that cause it. The bench therefore drives inputs on a falling edge and compares the outputs on the next falling edge, after exactly one rising edge has passed. bus_oe depends only on the current inputs, so it is checked a fixed 1 ns after the enables or selects change, with no clock edge in between. The reset clear needs no clock edge at all: the bench pulls mr_n low between edges and checks the outputs before the next rising edge comes.

// File: rtl/usr_pkg.sv
// Package: shared mode type for the universal shift register.
// Assumes the select pair is read as {sel1, sel0}.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/usr_mode_decode.sv
// Module: usr_mode_decode
// Turns the select pins into a mode and decides whether the bus is driven.
// Assumes the enables are active low. Load mode always releases the bus.
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic        sel0,
    input  logic        sel1,
    input  logic        oe1_n,
    input  logic        oe2_n,
    output shift_mode_e mode,
    output logic        drive_en
);

    logic enables_on;

    // Map the select pair to a mode.
    always_comb begin
        mode = shift_mode_e'({sel1, sel0});
    end

    // Drive the bus only when both enables are on and the mode is not load.
    always_comb begin
        enables_on = !oe1_n && !oe2_n;
        drive_en   = enables_on && (mode != MODE_LOAD);
    end

endmodule

// File: rtl/usr_shift_core.sv
// Module: usr_shift_core
// The storage bits with a per-bit next-value selector.
// Assumes WIDTH >= 2. The clear is asynchronous and active low.
module usr_shift_core
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mr_n,
    input  shift_mode_e      mode,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] nxt;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic from_below;
            logic from_above;

            // Source for an upward shift: neighbour below, or the low serial input.
            if (i == 0) begin : g_lo_end
                always_comb from_below = ser_lo;
            end else begin : g_lo_mid
                always_comb from_below = q[i-1];
            end

            // Source for a downward shift: neighbour above, or the high serial input.
            if (i == TOP) begin : g_hi_end
                always_comb from_above = ser_hi;
            end else begin : g_hi_mid
                always_comb from_above = q[i+1];
            end

            // Choose this bit's next value from the mode.
            always_comb begin
                unique case (mode)
                    MODE_UP:   nxt[i] = from_below;
                    MODE_DOWN: nxt[i] = from_above;
                    MODE_LOAD: nxt[i] = par_in[i];
                    default:   nxt[i] = q[i];
                endcase
            end
        end
    endgenerate

    // Storage update, with the master clear taking effect at once.
    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/usr_shift_reg.sv
// Module: usr_shift_reg (top)
// Universal shift register with a split three-state bus: bus_in/bus_out/bus_oe.
// Assumes something outside the block resolves bus_out and bus_oe into a real bus.
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mr_n,
    input  logic             sel0,
    input  logic             sel1,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic             ser_lo_in,
    input  logic             ser_hi_in,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             tap_lo,
    output logic             tap_hi
);

    shift_mode_e      mode;
    logic [WIDTH-1:0] store;

    usr_mode_decode u_dec (
        .sel0     (sel0),
        .sel1     (sel1),
        .oe1_n    (oe1_n),
        .oe2_n    (oe2_n),
        .mode     (mode),
        .drive_en (bus_oe)
    );

    usr_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .mr_n   (mr_n),
        .mode   (mode),
        .ser_lo (ser_lo_in),
        .ser_hi (ser_hi_in),
        .par_in (bus_in),
        .q      (store)
    );

    // Present the contents on the bus and on the two serial taps.
    always_comb begin
        bus_out = store;
        tap_lo  = store[0];
        tap_hi  = store[WIDTH-1];
    end

endmodule

// File: rtl/usr_shift_reg_chk.sv
// Module: usr_shift_reg_chk
// Property checker bound to usr_shift_reg. It sees only the top module's ports.
module usr_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             mr_n,
    input logic             sel0,
    input logic             sel1,
    input logic             oe1_n,
    input logic             oe2_n,
    input logic             ser_lo_in,
    input logic             ser_hi_in,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             tap_lo,
    input logic             tap_hi
);

    p_hold_r1: assert property (@(posedge clk) disable iff (!mr_n)
        (!sel1 && !sel0) |=> $stable(bus_out));

    p_shift_up_r2: assert property (@(posedge clk) disable iff (!mr_n)
        (!sel1 && sel0) |=> (bus_out[WIDTH-1:1] == $past(bus_out[WIDTH-2:0]))
                            && (tap_lo == $past(ser_lo_in)));

    p_shift_down_r3: assert property (@(posedge clk) disable iff (!mr_n)
        (sel1 && !sel0) |=> (bus_out[WIDTH-2:0] == $past(bus_out[WIDTH-1:1]))
                            && (tap_hi == $past(ser_hi_in)));

    p_load_r4: assert property (@(posedge clk) disable iff (!mr_n)
        (sel1 && sel0) |=> (bus_out == $past(bus_in)));

    p_clear_r5: assert property (@(posedge clk)
        !mr_n |-> (bus_out == '0));

    p_float_in_load_r7: assert property (@(posedge clk) disable iff (!mr_n)
        (sel1 && sel0) |-> !bus_oe);

    p_enable_off_r8: assert property (@(posedge clk) disable iff (!mr_n)
        (oe1_n || oe2_n) |-> !bus_oe);

    p_drive_r6: assert property (@(posedge clk) disable iff (!mr_n)
        (!oe1_n && !oe2_n && !(sel1 && sel0)) |-> bus_oe);

endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/usr_shift_reg_tb_top.sv
// Directed bench for usr_shift_reg: one task per scenario, each checking its own results.
module usr_shift_reg_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         mr_n = 1'b0;
    logic         sel0 = 1'b0, sel1 = 1'b0;
    logic         oe1_n = 1'b1, oe2_n = 1'b1;
    logic         ser_lo_in = 1'b0, ser_hi_in = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe, tap_lo, tap_hi;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    usr_shift_reg #(.WIDTH(W)) dut_i (
        .clk(clk), .mr_n(mr_n), .sel0(sel0), .sel1(sel1),
        .oe1_n(oe1_n), .oe2_n(oe2_n), .ser_lo_in(ser_lo_in), .ser_hi_in(ser_hi_in),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .tap_lo(tap_lo), .tap_hi(tap_hi)
    );

    // Two-unit chain: unit a holds the low bits, unit b the high bits.
    logic         c_sel0 = 1'b0, c_sel1 = 1'b0;
    logic [W-1:0] c_bus_a = '0, c_bus_b = '0;
    logic         c_ext_lo = 1'b0, c_ext_hi = 1'b0, c_recirc = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, a_lo, a_hi, b_lo, b_hi;
    logic         a_ser_lo;

    assign a_ser_lo = c_recirc ? b_hi : c_ext_lo;

    usr_shift_reg #(.WIDTH(W)) chain_a_i (
        .clk(clk), .mr_n(mr_n), .sel0(c_sel0), .sel1(c_sel1),
        .oe1_n(1'b0), .oe2_n(1'b0), .ser_lo_in(a_ser_lo), .ser_hi_in(b_lo),
        .bus_in(c_bus_a), .bus_out(a_out), .bus_oe(a_oe),
        .tap_lo(a_lo), .tap_hi(a_hi)
    );

    usr_shift_reg #(.WIDTH(W)) chain_b_i (
        .clk(clk), .mr_n(mr_n), .sel0(c_sel0), .sel1(c_sel1),
        .oe1_n(1'b0), .oe2_n(1'b0), .ser_lo_in(a_hi), .ser_hi_in(c_ext_hi),
        .bus_in(c_bus_b), .bus_out(b_out), .bus_oe(b_oe),
        .tap_lo(b_lo), .tap_hi(b_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference next value, computed from the requirements.
    function automatic logic [W-1:0] ref_next(input logic [W-1:0] q, input logic [1:0] m,
                                              input logic slo, input logic shi,
                                              input logic [W-1:0] p);
        case (m)
            2'b01:   ref_next = {q[W-2:0], slo};
            2'b10:   ref_next = {shi, q[W-1:1]};
            2'b11:   ref_next = p;
            default: ref_next = q;
        endcase
    endfunction

    // One rising edge, returning to the falling edge where checks are made.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        {sel1, sel0} = m;
    endtask

    task automatic do_load(input logic [W-1:0] v);
        set_mode(2'b11);
        bus_in = v;
        tick();
    endtask

    task automatic t_reset_state();
        chk("R5 reset contents", 32'(bus_out), 32'h0);
        chk("R9 reset taps", 32'({tap_hi, tap_lo}), 32'h0);
        chk("R8 reset bus_oe", 32'(bus_oe), 32'h0);
        @(negedge clk);
        mr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_hold();
        do_load(8'h3C);
        set_mode(2'b00);
        bus_in = 8'hFF;
        ser_lo_in = 1'b1;
        ser_hi_in = 1'b1;
        tick();
        tick();
        chk("R1 hold keeps contents", 32'(bus_out), 32'h3C);
    endtask

    task automatic t_shift_up();
        logic [W-1:0] m;
        do_load(8'h81);
        m = 8'h81;
        set_mode(2'b01);
        for (int k = 0; k < 5; k++) begin
            ser_lo_in = k[0];
            m = ref_next(m, 2'b01, ser_lo_in, ser_hi_in, bus_in);
            tick();
            chk("R2 shift up", 32'(bus_out), 32'(m));
        end
        chk("R9 tap_lo tracks bit0", 32'(tap_lo), 32'(m[0]));
    endtask

    task automatic t_shift_down();
        logic [W-1:0] m;
        do_load(8'h81);
        m = 8'h81;
        set_mode(2'b10);
        for (int k = 0; k < 5; k++) begin
            ser_hi_in = ~k[0];
            m = ref_next(m, 2'b10, ser_lo_in, ser_hi_in, bus_in);
            tick();
            chk("R3 shift down", 32'(bus_out), 32'(m));
        end
        chk("R9 tap_hi tracks top bit", 32'(tap_hi), 32'(m[W-1]));
    endtask

    task automatic t_load_float();
        oe1_n = 1'b0;
        oe2_n = 1'b0;
        set_mode(2'b00);
        #1;
        chk("R6 driven with enables low", 32'(bus_oe), 32'h1);
        set_mode(2'b11);
        bus_in = 8'h5A;
        #1;
        chk("R7 load floats bus", 32'(bus_oe), 32'h0);
        @(negedge clk);
        tick();
        chk("R4 load with enables low", 32'(bus_out), 32'h5A);
        oe1_n = 1'b1;
        bus_in = 8'hC3;
        tick();
        chk("R4 load with enables high", 32'(bus_out), 32'hC3);
        set_mode(2'b00);
    endtask

    task automatic t_enables();
        set_mode(2'b01);
        oe1_n = 1'b1; oe2_n = 1'b0; #1;
        chk("R8 oe1_n high", 32'(bus_oe), 32'h0);
        oe1_n = 1'b0; oe2_n = 1'b1; #1;
        chk("R8 oe2_n high", 32'(bus_oe), 32'h0);
        chk("R9 taps valid while floating", 32'({tap_hi, tap_lo}), 32'({bus_out[W-1], bus_out[0]}));
        oe2_n = 1'b0; set_mode(2'b10); #1;
        chk("R6 driven in shift down", 32'(bus_oe), 32'h1);
        set_mode(2'b00);
        @(negedge clk);
    endtask

    task automatic t_random();
        logic [W-1:0] m;
        logic         exp_oe;
        do_load(8'h96);
        m = 8'h96;
        for (int k = 0; k < 300; k++) begin
            {sel1, sel0} = 2'($urandom_range(0, 3));
            ser_lo_in = 1'($urandom_range(0, 1));
            ser_hi_in = 1'($urandom_range(0, 1));
            bus_in = W'($urandom_range(0, 255));
            oe1_n = 1'($urandom_range(0, 1));
            oe2_n = 1'($urandom_range(0, 1));
            #1;
            exp_oe = !oe1_n && !oe2_n && !(sel0 && sel1);
            chk("R6 random bus_oe", 32'(bus_oe), 32'(exp_oe));
            m = ref_next(m, {sel1, sel0}, ser_lo_in, ser_hi_in, bus_in);
            @(negedge clk);
            chk("R1 R2 R3 R4 random contents", 32'(bus_out), 32'(m));
        end
        set_mode(2'b00);
        oe1_n = 1'b1; oe2_n = 1'b1;
    endtask

    task automatic t_mid_reset();
        do_load(8'hA5);
        set_mode(2'b11);
        bus_in = 8'hFF;
        @(posedge clk);
        #2;
        mr_n = 1'b0;
        #1;
        chk("R5 clear without edge", 32'(bus_out), 32'h0);
        @(negedge clk);
        tick();
        chk("R5 clear overrides load", 32'(bus_out), 32'h0);
        mr_n = 1'b1;
        set_mode(2'b00);
        tick();
        chk("R5 stays clear after release", 32'(bus_out), 32'h0);
    endtask

    task automatic t_chain();
        logic [2*W-1:0] m;
        {c_sel1, c_sel0} = 2'b11;
        c_bus_a = 8'h12; c_bus_b = 8'hF0;
        tick();
        m = 16'hF012;
        chk("R10 chain load", 32'({b_out, a_out}), 32'(m));
        {c_sel1, c_sel0} = 2'b01;
        for (int k = 0; k < 6; k++) begin
            c_ext_lo = k[1];
            m = {m[2*W-2:0], c_ext_lo};
            tick();
            chk("R10 chain shift up", 32'({b_out, a_out}), 32'(m));
        end
        {c_sel1, c_sel0} = 2'b10;
        for (int k = 0; k < 6; k++) begin
            c_ext_hi = k[0];
            m = {c_ext_hi, m[2*W-1:1]};
            tick();
            chk("R10 chain shift down", 32'({b_out, a_out}), 32'(m));
        end
        {c_sel1, c_sel0} = 2'b11;
        c_bus_a = 8'h01; c_bus_b = 8'h80;
        tick();
        c_recirc = 1'b1;
        {c_sel1, c_sel0} = 2'b01;
        for (int k = 0; k < 2 * W; k++) tick();
        chk("R10 full recirculation", 32'({b_out, a_out}), 32'h8001);
        tick();
        chk("R10 recirculate wrap", 32'({b_out, a_out}), 32'h0003);
        {c_sel1, c_sel0} = 2'b00;
        c_recirc = 1'b0;
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset_state();
                t_hold();
                t_shift_up();
                t_shift_down();
                t_load_float();
                t_enables();
                t_random();
                t_mid_reset();
                t_chain();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule